// File: doc/BRIEF.md
# Clock Divider Setting Solver

This block picks the best way to reach a requested clock rate from a set of candidate source clocks. A caller presents a requested output rate and the current rate of every source as unsigned integers, then pulses `start`. For each source the block works out a prescaler and a post-divider that bring that source as close as it can get to the request from below. It then reports which source wins, the two divider settings in register-ready form, and the rate those settings produce.

Only one source, the designated wide-range input, can use the prescaler for more than a divide-by-one. On every other source the post-divider alone carries the whole ratio. On the wide-range input a large ratio is split in steps: the post-divider grows from 1 to 4 as the ratio passes each multiple of the prescaler's range. All the divisions go through one shared restoring divider that retires one quotient bit per clock. The search over the sources therefore takes a few hundred cycles. The result is announced with a one-cycle `done` pulse and then held.

Top module: `rate_setting_solver`

## Requirements
- R1: A `start` pulse while the block is idle captures `req_rate` and `in_rate`. From the next cycle `busy` stays high until the result is ready, and then `done` is high for exactly one cycle with `busy` low. A `start` seen while `busy` is high is ignored and does not change the result.
- R2: If the request exceeds a source's rate, that source is solved as if the request equalled its rate. This gives a total ratio of 1, and the source's full rate is achieved.
- R3: A source's total ratio is the ceiling of its rate divided by the (clamped) request.
- R4: For sources 0 to 2, and for source 3 when the total ratio is 4 or less, the prescaler is 1 and the post-divider equals the total ratio. Any ratio above 4 is limited to 4.
- R5: For source 3 with a total ratio above 4, the settings depend on the ratio. Below 32 the prescaler equals the ratio and the post-divider is 1. Below 64 they are ceil(ratio/2) and 2. Below 96 they are ceil(ratio/3) and 3. Otherwise they are ceil(ratio/4) and 4, with the prescaler limited to 32.
- R6: `pre_code` (5 bits) is the prescaler minus one and `post_code` (2 bits) is the post-divider minus one.
- R7: The achieved rate of a source is floor(floor(rate / prescaler) / post-divider).
- R8: The selected source is the one with the highest achieved rate that does not exceed the request. A later source replaces the current best only with a strictly higher rate, so a tie keeps the lower-numbered source.
- R9: A source whose rate is zero is treated as absent and can never be selected.
- R10: If no source qualifies, `err` is 1 and `sel_idx`, `pre_code`, `post_code` and `out_rate` are all 0. This includes the case of a zero request.
- R11: `err`, `sel_idx`, `pre_code`, `post_code` and `out_rate` change only in the cycle where `done` is high. They hold their values between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a search; honoured only while idle |
| req_rate | input | 32 | Requested output rate |
| in_rate | input | 4x32 | Rate of each source; element i belongs to source i |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| err | output | 1 | No source can meet the request |
| sel_idx | output | 2 | Chosen source |
| pre_code | output | 5 | Prescaler minus one |
| post_code | output | 2 | Post-divider minus one |
| out_rate | output | 32 | Rate achieved with the chosen settings |

## Verification
The assertions assume that the divider is only ever launched with a non-zero divisor. They also assume that `req_rate` and `in_rate` only matter at the `start` edge, because the block works from its captured copies. The stimulus changes `req_rate` and `in_rate` freely while the block is busy or idle, and it includes zero rates and zero requests so that the skip path is exercised rather than the divider. Random cases draw rates over many magnitudes so that all four split steps and the prescaler limit are reached. Each result is compared against a behavioural model in the bench.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RATIO,
    ST_SPLIT,
    ST_ACHV,
    ST_NEXT,
    ST_DONE
  } solve_st_e;

endpackage

// File: rtl/rss_divider.sv
module rss_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dvs_q, dvs_d;
  logic [W-1:0]     dvd_q, dvd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [W:0]       shifted;
  logic [W:0]       diff;
  logic             fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = ~diff[W];

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    dvd_d  = dvd_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      dvs_d = divisor;
      dvd_d = dividend;
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(W - 1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvs_q  <= dvs_d;
      dvd_q  <= dvd_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

  // R3: every quotient handed out is an exact integer division
  p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (((2*W)'(quo_q) * (2*W)'(dvs_q) + (2*W)'(rem_q)) == (2*W)'(dvd_q))
               && (rem_q < dvs_q));

  // R3: a new division never starts on top of one in flight
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run_q);

endmodule

// File: rtl/rss_splitter.sv
module rss_splitter #(
  parameter int RATE_W   = 32,
  parameter int PRE_MAX  = 32,
  parameter int POST_MAX = 4,
  parameter int PRE_VW   = 6,
  parameter int POST_VW  = 3
) (
  input  logic [RATE_W-1:0]  ratio,
  input  logic               wide_src,
  output logic [PRE_VW-1:0]  pre_val,
  output logic [POST_VW-1:0] post_val
);

  logic            found;
  logic [RATE_W:0] quot;

  always_comb begin
    pre_val  = PRE_VW'(1);
    post_val = POST_VW'(1);
    found    = 1'b0;
    quot     = '0;
    if (!wide_src || ratio <= RATE_W'(POST_MAX)) begin
      if (ratio > RATE_W'(POST_MAX)) begin
        post_val = POST_VW'(POST_MAX);
      end else if (ratio != '0) begin
        post_val = ratio[POST_VW-1:0];
      end
    end else begin
      for (int k = 1; k <= POST_MAX; k++) begin
        if (!found && (k == POST_MAX || ratio < RATE_W'(k * PRE_MAX))) begin
          found    = 1'b1;
          quot     = ({1'b0, ratio} + (RATE_W+1)'(k - 1)) / (RATE_W+1)'(k);
          pre_val  = (quot > (RATE_W+1)'(PRE_MAX)) ? PRE_VW'(PRE_MAX)
                                                   : quot[PRE_VW-1:0];
          post_val = POST_VW'(k);
        end
      end
    end
  end

endmodule

// File: rtl/rss_best.sv
module rss_best #(
  parameter int RATE_W = 32,
  parameter int IDX_W  = 2,
  parameter int PRE_W  = 5,
  parameter int POST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cand_en,
  input  logic [IDX_W-1:0]  cand_idx,
  input  logic [RATE_W-1:0] cand_rate,
  input  logic [PRE_W-1:0]  cand_pre,
  input  logic [POST_W-1:0] cand_post,
  input  logic [RATE_W-1:0] limit,
  output logic              best_found,
  output logic [IDX_W-1:0]  best_idx,
  output logic [RATE_W-1:0] best_rate,
  output logic [PRE_W-1:0]  best_pre,
  output logic [POST_W-1:0] best_post
);

  logic              found_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RATE_W-1:0] rate_q;
  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic              take;

  assign take = cand_en && (cand_rate <= limit) && (cand_rate > rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      idx_q   <= '0;
      rate_q  <= '0;
      pre_q   <= '0;
      post_q  <= '0;
    end else if (clear) begin
      found_q <= 1'b0;
      idx_q   <= '0;
      rate_q  <= '0;
      pre_q   <= '0;
      post_q  <= '0;
    end else if (take) begin
      found_q <= 1'b1;
      idx_q   <= cand_idx;
      rate_q  <= cand_rate;
      pre_q   <= cand_pre;
      post_q  <= cand_post;
    end
  end

  assign best_found = found_q;
  assign best_idx   = idx_q;
  assign best_rate  = rate_q;
  assign best_pre   = pre_q;
  assign best_post  = post_q;

  // R8: within one search the best rate only ever rises
  p_best_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> rate_q >= $past(rate_q));

  // R8: a held best never exceeds the request it was chosen for
  p_best_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && !clear) |-> rate_q <= limit);

endmodule

// File: rtl/rate_setting_solver.sv
module rate_setting_solver #(
  parameter int RATE_W   = 32,
  parameter int NUM_IN   = 4,
  parameter int WIDE_IN  = 3,
  parameter int PRE_MAX  = 32,
  parameter int POST_MAX = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [RATE_W-1:0]              req_rate,
  input  logic [NUM_IN-1:0][RATE_W-1:0]  in_rate,
  output logic                           busy,
  output logic                           done,
  output logic                           err,
  output logic [$clog2(NUM_IN)-1:0]      sel_idx,
  output logic [$clog2(PRE_MAX)-1:0]     pre_code,
  output logic [$clog2(POST_MAX)-1:0]    post_code,
  output logic [RATE_W-1:0]              out_rate
);

  import rss_pkg::*;

  localparam int IDX_W   = $clog2(NUM_IN);
  localparam int PRE_W   = $clog2(PRE_MAX);
  localparam int POST_W  = $clog2(POST_MAX);
  localparam int PRE_VW  = PRE_W + 1;
  localparam int POST_VW = POST_W + 1;
  localparam int PROD_W  = PRE_VW + POST_VW;

  // reset: asserted at once, released two clocks later
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  solve_st_e                    st_q, st_d;
  logic [RATE_W-1:0]            req_q;
  logic [NUM_IN-1:0][RATE_W-1:0] rates_q;
  logic [IDX_W-1:0]             idx_q, idx_d;
  logic [RATE_W-1:0]            ratio_q, ratio_d;
  logic [PRE_VW-1:0]            pre_q, pre_d;
  logic [POST_VW-1:0]           post_q, post_d;
  logic                         err_q, err_d;
  logic [IDX_W-1:0]             sel_q, sel_d;
  logic [PRE_W-1:0]             prec_q, prec_d;
  logic [POST_W-1:0]            postc_q, postc_d;
  logic [RATE_W-1:0]            orate_q, orate_d;

  logic              accept;
  logic [RATE_W-1:0] cur_rate;
  logic [RATE_W-1:0] clamped;
  logic              div_go;
  logic [RATE_W-1:0] div_dvs;
  logic              div_done;
  logic [RATE_W-1:0] div_quo;
  logic [RATE_W-1:0] div_rem;
  logic [PRE_VW-1:0] pre_s;
  logic [POST_VW-1:0] post_s;
  logic [PROD_W-1:0] prod;
  logic              trk_clear;
  logic              cand_en;
  logic              best_found;
  logic [IDX_W-1:0]  best_idx;
  logic [RATE_W-1:0] best_rate;
  logic [PRE_W-1:0]  best_pre;
  logic [POST_W-1:0] best_post;

  assign accept   = (st_q == ST_IDLE) && start;
  assign cur_rate = rates_q[idx_q];
  assign clamped  = (req_q < cur_rate) ? req_q : cur_rate;
  assign prod     = PROD_W'(pre_s) * PROD_W'(post_s);

  rss_divider #(.W(RATE_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go        (div_go),
    .dividend  (cur_rate),
    .divisor   (div_dvs),
    .done      (div_done),
    .quotient  (div_quo),
    .remainder (div_rem)
  );

  rss_splitter #(
    .RATE_W  (RATE_W),
    .PRE_MAX (PRE_MAX),
    .POST_MAX(POST_MAX),
    .PRE_VW  (PRE_VW),
    .POST_VW (POST_VW)
  ) u_split (
    .ratio    (ratio_q),
    .wide_src (idx_q == IDX_W'(WIDE_IN)),
    .pre_val  (pre_s),
    .post_val (post_s)
  );

  rss_best #(
    .RATE_W(RATE_W),
    .IDX_W (IDX_W),
    .PRE_W (PRE_W),
    .POST_W(POST_W)
  ) u_best (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clear      (trk_clear),
    .cand_en    (cand_en),
    .cand_idx   (idx_q),
    .cand_rate  (div_quo),
    .cand_pre   (PRE_W'(pre_q - 1'b1)),
    .cand_post  (POST_W'(post_q - 1'b1)),
    .limit      (req_q),
    .best_found (best_found),
    .best_idx   (best_idx),
    .best_rate  (best_rate),
    .best_pre   (best_pre),
    .best_post  (best_post)
  );

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    ratio_d   = ratio_q;
    pre_d     = pre_q;
    post_d    = post_q;
    err_d     = err_q;
    sel_d     = sel_q;
    prec_d    = prec_q;
    postc_d   = postc_q;
    orate_d   = orate_q;
    div_go    = 1'b0;
    div_dvs   = clamped;
    trk_clear = 1'b0;
    cand_en   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          idx_d     = '0;
          trk_clear = 1'b1;
          st_d      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cur_rate == '0 || req_q == '0) begin
          st_d = ST_NEXT;
        end else begin
          div_go = 1'b1;
          st_d   = ST_RATIO;
        end
      end
      ST_RATIO: begin
        if (div_done) begin
          ratio_d = div_quo + RATE_W'(div_rem != '0);
          st_d    = ST_SPLIT;
        end
      end
      ST_SPLIT: begin
        div_go  = 1'b1;
        div_dvs = RATE_W'(prod);
        pre_d   = pre_s;
        post_d  = post_s;
        st_d    = ST_ACHV;
      end
      ST_ACHV: begin
        if (div_done) begin
          cand_en = 1'b1;
          st_d    = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (idx_q == IDX_W'(NUM_IN - 1)) begin
          err_d   = ~best_found;
          sel_d   = best_found ? best_idx  : '0;
          prec_d  = best_found ? best_pre  : '0;
          postc_d = best_found ? best_post : '0;
          orate_d = best_found ? best_rate : '0;
          st_d    = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_CHECK;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      req_q   <= '0;
      rates_q <= '0;
      idx_q   <= '0;
      ratio_q <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      err_q   <= 1'b0;
      sel_q   <= '0;
      prec_q  <= '0;
      postc_q <= '0;
      orate_q <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      ratio_q <= ratio_d;
      pre_q   <= pre_d;
      post_q  <= post_d;
      err_q   <= err_d;
      sel_q   <= sel_d;
      prec_q  <= prec_d;
      postc_q <= postc_d;
      orate_q <= orate_d;
      if (accept) begin
        req_q   <= req_rate;
        rates_q <= in_rate;
      end
    end
  end

  assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done      = (st_q == ST_DONE);
  assign err       = err_q;
  assign sel_idx   = sel_q;
  assign pre_code  = prec_q;
  assign post_code = postc_q;
  assign out_rate  = orate_q;

  // R1: done lasts a single cycle
  p_done_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R1: done and busy never overlap
  p_done_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy);

  // R1: a start during a search leaves the captured request alone
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && start) |=> req_q == $past(req_q));

  // R2: a request at or above the source rate yields a ratio of one
  p_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_SPLIT && req_q >= cur_rate) |-> ratio_q == RATE_W'(1));

  // R8: a reported rate is non-zero and within the request
  p_within_request_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !err) |-> (out_rate <= req_q) && (out_rate != '0));

  // R9: a source with zero rate is never reported
  p_skip_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !err) |-> rates_q[sel_idx] != '0);

  // R10: an error result carries all-zero fields
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && err) |-> (sel_idx == '0) && (pre_code == '0)
                      && (post_code == '0) && (out_rate == '0));

  // R11: result outputs move only with done
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable({err, sel_idx, pre_code, post_code, out_rate}) |-> done);

endmodule

// File: tb/tb_rate_setting_solver.sv
module tb_rate_setting_solver;

  localparam int CLK_PERIOD = 10;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [31:0]     req_rate;
  logic [3:0][31:0] in_rate;
  logic            busy;
  logic            done;
  logic            err;
  logic [1:0]      sel_idx;
  logic [4:0]      pre_code;
  logic [1:0]      post_code;
  logic [31:0]     out_rate;

  int tests;
  int fails;
  bit in_flight;
  bit finished;

  rate_setting_solver dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_rate  (req_rate),
    .in_rate   (in_rate),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .sel_idx   (sel_idx),
    .pre_code  (pre_code),
    .post_code (post_code),
    .out_rate  (out_rate)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model written from the requirements
  function automatic void model(input longint req, input logic [3:0][31:0] rates,
                                output bit e, output int s, output int pc,
                                output int qc, output longint r);
    longint best;
    best = 0; e = 1; s = 0; pc = 0; qc = 0; r = 0;
    for (int i = 0; i < 4; i++) begin
      longint p, c, tot, pre, post, ach;
      p = longint'(rates[i]);
      if (p == 0 || req == 0) continue;
      c   = (req > p) ? p : req;
      tot = (p + c - 1) / c;
      if (i != 3 || tot <= 4) begin
        pre = 1; post = (tot > 4) ? 4 : tot;
      end else if (tot < 32) begin
        pre = tot; post = 1;
      end else if (tot < 64) begin
        pre = (tot + 1) / 2; post = 2;
      end else if (tot < 96) begin
        pre = (tot + 2) / 3; post = 3;
      end else begin
        pre = (tot + 3) / 4; post = 4;
      end
      if (pre > 32) pre = 32;
      ach = (p / pre) / post;
      if (ach <= req && ach > best) begin
        best = ach; e = 0; s = i; pc = int'(pre) - 1; qc = int'(post) - 1; r = ach;
      end
    end
  endfunction

  task automatic check_result(input string tag, input longint req,
                              input logic [3:0][31:0] rates);
    bit     e;
    int     s, pc, qc;
    longint r;
    model(req, rates, e, s, pc, qc, r);
    tests++;
    if (err !== e || (!e && (sel_idx !== 2'(s) || pre_code !== 5'(pc)
        || post_code !== 2'(qc) || out_rate !== 32'(r)))
        || (e && (sel_idx !== 0 || pre_code !== 0 || post_code !== 0 || out_rate !== 0))) begin
      fails++;
      $display("FAIL %s: got err=%0d sel=%0d pre=%0d post=%0d rate=%0d exp err=%0d sel=%0d pre=%0d post=%0d rate=%0d",
               tag, err, sel_idx, pre_code, post_code, out_rate, e, s, pc, qc, r);
    end
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_case(input string tag, input logic [31:0] rq,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d);
    logic [3:0][31:0] rr;
    rr = {d, c, b, a};
    @(negedge clk);
    req_rate = rq; in_rate = rr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_flight = 1'b1;
    wait_done();
    in_flight = 1'b0;
    check_result(tag, longint'(rq), rr);
    tests++;
    if (busy !== 1'b0) begin
      fails++;
      $display("FAIL R1: busy=%0d with done, expected 0", busy);
    end
    @(negedge clk);
    tests++;
    if (done !== 1'b0) begin
      fails++;
      $display("FAIL R1: done=%0d one cycle later, expected 0", done);
    end
  endtask

  // every clock of a search: busy high until done
  always @(negedge clk) begin
    if (in_flight && done !== 1'b1) begin
      tests++;
      if (busy !== 1'b1) begin
        fails++;
        $display("FAIL R1: busy=%0d during search, expected 1", busy);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0][31:0] keep_rates;
    logic [31:0]      keep_req;
    tests = 0; fails = 0; in_flight = 0; finished = 0;
    start = 0; req_rate = 0; in_rate = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    tests++;
    if (busy !== 0 || done !== 0 || err !== 0 || out_rate !== 0 || sel_idx !== 0) begin
      fails++;
      $display("FAIL R11: reset state busy=%0d done=%0d err=%0d rate=%0d, expected all 0",
               busy, done, err, out_rate);
    end

    run_case("R2 request above every source", 1000, 100, 200, 300, 400);
    run_case("R3 ceiling ratio 4", 300, 1000, 0, 0, 0);
    run_case("R4 post limited to 4 gives no fit", 100, 1000, 0, 0, 0);
    run_case("R5 wide source ratio 10", 100, 0, 0, 0, 1000);
    run_case("R5 wide source ratio 50", 100, 0, 0, 0, 5000);
    run_case("R5 wide source ratio 90", 100, 0, 0, 0, 9000);
    run_case("R6 wide source ratio 120", 100, 0, 0, 0, 12000);
    run_case("R5 prescaler limit", 100, 0, 0, 0, 100000);
    run_case("R7 floor of achieved rate", 400, 1001, 0, 0, 0);
    run_case("R8 tie keeps lower source", 300, 400, 400, 0, 0);
    run_case("R8 source 0 wins", 500, 1000, 0, 990, 0);
    run_case("R8 source 2 wins", 495, 1000, 0, 990, 0);
    run_case("R9 all sources absent", 100, 0, 0, 0, 0);
    run_case("R10 zero request", 0, 10, 20, 30, 40);
    run_case("R4 wide source small ratio", 250, 0, 0, 0, 1000);

    // R1: a second start during a search is ignored
    @(negedge clk);
    req_rate = 300; in_rate = {32'd0, 32'd0, 32'd0, 32'd1000}; start = 1;
    keep_req = 300; keep_rates = in_rate;
    @(negedge clk);
    start = 0; in_flight = 1;
    repeat (5) @(negedge clk);
    req_rate = 7; in_rate = {32'd70, 32'd70, 32'd70, 32'd70}; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    in_flight = 0;
    check_result("R1 start while busy ignored", longint'(keep_req), keep_rates);

    // R11: outputs hold while idle and inputs move
    req_rate = 5; in_rate = {32'd9, 32'd9, 32'd9, 32'd9};
    repeat (12) @(negedge clk);
    check_result("R11 result held while idle", longint'(keep_req), keep_rates);

    for (int n = 0; n < 150; n++) begin
      logic [31:0] rq;
      logic [31:0] v [4];
      for (int i = 0; i < 4; i++) begin
        v[i] = $urandom() >> ($urandom() % 30);
        if (($urandom() % 6) == 0) v[i] = 0;
      end
      rq = $urandom() >> ($urandom() % 32);
      if ((n % 5) == 0) v[3] = rq * (1 + $urandom() % 140);
      run_case("R8 random search", rq, v[0], v[1], v[2], v[3]);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule